// File: doc/BRIEF.md
# Sensor Sample Packetizer

This block turns one monitor sample record into one 24-bit network flit and hands it to one of two injection queues in front of a router. A record carries a priority flag, the 4-bit address of the router that collected it, a 3-bit select naming the monitor behind that router, and an 8-bit reading. The block adds the fixed address of the sink router. When the stamp enable is high, it also adds a 4-bit sample time taken from a wrap-around timer. The finished flit goes to the priority queue when the record is flagged as critical, and to the regular queue otherwise.

The block holds one record at a time. A record is taken on a valid/ready handshake and is pushed into its class queue in the next cycle, or in the first later cycle in which that queue reports free space. While the record waits, the input stays not-ready, so no sample is ever lost. When the record goes out in the same cycle that a new one is offered, the new record is taken at once, which sustains one flit per cycle. The control path is a two-state machine. S_EMPTY holds no record. S_LOADED holds one record. The transitions are: take (S_EMPTY to S_LOADED on a handshake), stall (S_LOADED stays while the target queue is full), swap (S_LOADED stays on a push plus a new handshake), and drain (S_LOADED to S_EMPTY on a push with no new record).

Top module: `sensor_flit_packer`

## Requirements
- R1: Each flit has this layout from bit 23 down: priority at [23], sink address at [22:19], source router at [18:15], monitor select at [14:12], reading at [11:4] and sample time at [3:0]. All fields other than the sink address and the sample time are copied from the accepted record.
- R2: A record with the priority flag at 1 is pushed only into the priority queue (pri_push), with bit 23 set. A record with the flag at 0 is pushed only into the regular queue (reg_push), with bit 23 clear.
- R3: The sink address field of every flit equals the SINK_ADDR parameter.
- R4: With stamp_en high during the handshake cycle, bits [3:0] hold the timer value of that handshake cycle, even when the push comes later. With stamp_en low, bits [3:0] are zero.
- R5: The timer is 0 in the first cycle after reset, rises by one per cycle up to TS_MAX, and then returns to 0.
- R6: No push is made into a queue while that queue's full input is high.
- R7: While the held record's queue is full, in_ready is low and the record is kept unchanged. Records leave in the order they were accepted, and none is dropped.
- R8: in_ready is high when no record is held, or when the held record can be pushed in the current cycle. This allows one flit per cycle.
- R9: During and right after reset, no record is held, in_ready is high, and neither push is asserted.
- R10: At most one of reg_push and pri_push is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stamp_en | input | 1 | Append the sample time to the record taken this cycle |
| in_valid | input | 1 | A sample record is offered |
| in_ready | output | 1 | The record is taken this cycle when in_valid is high |
| in_prio | input | 1 | Critical sample flag |
| in_src | input | 4 | Source router address |
| in_sel | input | 3 | Monitor select |
| in_data | input | 8 | Monitor reading |
| reg_full | input | 1 | Regular injection queue cannot accept |
| reg_push | output | 1 | Write reg_flit into the regular queue |
| reg_flit | output | 24 | Flit for the regular queue |
| pri_full | input | 1 | Priority injection queue cannot accept |
| pri_push | output | 1 | Write pri_flit into the priority queue |
| pri_flit | output | 24 | Flit for the priority queue |

## Verification
The hardest case is a record that stalls behind its own full queue while the other queue is free, and stays held across a timer wrap before it leaves. The flit must then carry the time of its handshake, not the time of its push. The stimulus holds each full input for random runs of cycles and offers records of both classes on most cycles. A directed phase pins the priority queue full for longer than a timer period. Another directed phase takes a record on every cycle for two timer periods, so that the stamps can be checked across both wraps.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    localparam int FLIT_W  = 24;
    localparam int ADDR_W  = 4;
    localparam int SEL_W   = 3;
    localparam int VAL_W   = 8;
    localparam int STAMP_W = 4;

    // field positions, low to high
    localparam int STAMP_LSB = 0;
    localparam int VAL_LSB   = STAMP_LSB + STAMP_W;
    localparam int SEL_LSB   = VAL_LSB + VAL_W;
    localparam int SRC_LSB   = SEL_LSB + SEL_W;
    localparam int DST_LSB   = SRC_LSB + ADDR_W;
    localparam int PRI_BIT   = DST_LSB + ADDR_W;

    typedef struct packed {
        logic              prio;
        logic [ADDR_W-1:0] src;
        logic [SEL_W-1:0]  sel;
        logic [VAL_W-1:0]  value;
    } sample_t;

    typedef enum logic [0:0] {
        S_EMPTY  = 1'b0,
        S_LOADED = 1'b1
    } inj_state_t;

endpackage

// File: rtl/stamp_timer.sv
module stamp_timer #(
    parameter int W   = 4,
    parameter int MAX = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] LAST = W'(MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (count == LAST) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

    assert_timer_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count == LAST) |=> (count == '0));

    assert_timer_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count != LAST) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/flit_assembler.sv
module flit_assembler
    import sfp_pkg::*;
#(
    parameter int SINK_ADDR = 0
) (
    input  sample_t              rec,
    input  logic [STAMP_W-1:0]   stamp,
    input  logic                 stamp_on,
    output logic [FLIT_W-1:0]    flit
);
    localparam logic [ADDR_W-1:0] SINK = ADDR_W'(SINK_ADDR);

    always_comb begin
        flit = '0;
        flit[PRI_BIT]                      = rec.prio;
        flit[DST_LSB +: ADDR_W]            = SINK;
        flit[SRC_LSB +: ADDR_W]            = rec.src;
        flit[SEL_LSB +: SEL_W]             = rec.sel;
        flit[VAL_LSB +: VAL_W]             = rec.value;
        flit[STAMP_LSB +: STAMP_W]         = stamp_on ? stamp : '0;
    end

endmodule

// File: rtl/inject_fsm.sv
module inject_fsm
    import sfp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  sample_t             in_rec,
    input  logic [STAMP_W-1:0]  stamp_now,
    input  logic                stamp_en,
    input  logic                reg_full,
    input  logic                pri_full,
    output logic                in_ready,
    output sample_t             held_rec,
    output logic [STAMP_W-1:0]  held_stamp,
    output logic                held_stamp_on,
    output logic                push_reg,
    output logic                push_pri
);
    inj_state_t state, state_nx;
    logic blocked, take, send;

    // the held record's class queue cannot take it this cycle
    assign blocked = held_rec.prio ? pri_full : reg_full;
    assign take    = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_EMPTY:  if (take) state_nx = S_LOADED;
            S_LOADED: if (!blocked && !take) state_nx = S_EMPTY;
            default:  state_nx = S_EMPTY;
        endcase
    end

    always_comb begin
        in_ready = 1'b0;
        send     = 1'b0;
        unique case (state)
            S_EMPTY:  in_ready = 1'b1;
            S_LOADED: begin
                send     = !blocked;
                in_ready = !blocked;
            end
            default:  in_ready = 1'b0;
        endcase
        push_pri = send && held_rec.prio;
        push_reg = send && !held_rec.prio;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_rec      <= '0;
            held_stamp    <= '0;
            held_stamp_on <= 1'b0;
        end else if (take) begin
            held_rec      <= in_rec;
            held_stamp    <= stamp_now;
            held_stamp_on <= stamp_en;
        end
    end

    assert_hold_record_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOADED && blocked) |=>
            (state == S_LOADED && $stable(held_rec) && $stable(held_stamp)));

    assert_stall_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOADED && (push_reg == 1'b0) && (push_pri == 1'b0)) |-> !in_ready);

endmodule

// File: rtl/sensor_flit_packer.sv
module sensor_flit_packer
    import sfp_pkg::*;
#(
    parameter int SINK_ADDR = 9,
    parameter int TS_MAX    = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stamp_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_prio,
    input  logic [ADDR_W-1:0] in_src,
    input  logic [SEL_W-1:0]  in_sel,
    input  logic [VAL_W-1:0]  in_data,
    input  logic              reg_full,
    output logic              reg_push,
    output logic [FLIT_W-1:0] reg_flit,
    input  logic              pri_full,
    output logic              pri_push,
    output logic [FLIT_W-1:0] pri_flit
);
    localparam logic [ADDR_W-1:0] SINK = ADDR_W'(SINK_ADDR);

    sample_t              rec_in, held_rec;
    logic [STAMP_W-1:0]   stamp_now, held_stamp;
    logic                 held_stamp_on;
    logic [FLIT_W-1:0]    flit;

    assign rec_in = '{prio: in_prio, src: in_src, sel: in_sel, value: in_data};

    stamp_timer #(.W(STAMP_W), .MAX(TS_MAX)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .count (stamp_now)
    );

    inject_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_rec        (rec_in),
        .stamp_now     (stamp_now),
        .stamp_en      (stamp_en),
        .reg_full      (reg_full),
        .pri_full      (pri_full),
        .in_ready      (in_ready),
        .held_rec      (held_rec),
        .held_stamp    (held_stamp),
        .held_stamp_on (held_stamp_on),
        .push_reg      (reg_push),
        .push_pri      (pri_push)
    );

    flit_assembler #(.SINK_ADDR(SINK_ADDR)) u_asm (
        .rec      (held_rec),
        .stamp    (held_stamp),
        .stamp_on (held_stamp_on),
        .flit     (flit)
    );

    assign reg_flit = flit;
    assign pri_flit = flit;

    assert_one_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_push, pri_push}));

    assert_no_push_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_push |-> !reg_full) and (pri_push |-> !pri_full));

    assert_class_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_push |-> pri_flit[PRI_BIT]) and (reg_push |-> !reg_flit[PRI_BIT]));

    assert_sink_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_push || pri_push) |-> (flit[DST_LSB +: ADDR_W] == SINK));

    assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |=> (in_ready && !reg_push && !pri_push));

endmodule

// File: tb/sensor_flit_packer_test.sv
module sensor_flit_packer_test;
    localparam int SINK   = 9;
    localparam int TS_MAX = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stamp_en = 1'b0, in_valid = 1'b0, in_prio = 1'b0;
    logic [3:0] in_src = '0;
    logic [2:0] in_sel = '0;
    logic [7:0] in_data = '0;
    logic reg_full = 1'b0, pri_full = 1'b0;
    logic in_ready, reg_push, pri_push;
    logic [23:0] reg_flit, pri_flit;

    int total = 0, bad = 0;
    bit done = 0;
    bit have = 0, exp_pri = 0;
    logic [23:0] exp_flit = '0;
    int tcount = 0;

    always #4 clk = ~clk;

    sensor_flit_packer #(.SINK_ADDR(SINK), .TS_MAX(TS_MAX)) uut (
        .clk(clk), .rst_n(rst_n), .stamp_en(stamp_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_prio(in_prio),
        .in_src(in_src), .in_sel(in_sel), .in_data(in_data),
        .reg_full(reg_full), .reg_push(reg_push), .reg_flit(reg_flit),
        .pri_full(pri_full), .pri_push(pri_push), .pri_flit(pri_flit)
    );

    function automatic logic [23:0] build(bit p, logic [3:0] s, logic [2:0] m,
                                          logic [7:0] d, bit st, int ts);
        logic [3:0] t = st ? 4'(ts) : 4'd0;
        return {p, 4'(SINK), s, m, d, t};
    endfunction

    task automatic chk(bit ok, string req, logic [23:0] act, logic [23:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic cycle_check();
        bit hf, er;
        logic [23:0] got;
        #1;
        hf = exp_pri ? pri_full : reg_full;
        er = !have || !hf;
        chk(in_ready == er, "R7 R8 in_ready", 24'(in_ready), 24'(er));
        chk(!(reg_push && pri_push), "R10 single push", {reg_push, pri_push}, 24'd0);
        if (have && !hf) begin
            got = exp_pri ? pri_flit : reg_flit;
            chk(exp_pri ? (pri_push && !reg_push) : (reg_push && !pri_push),
                "R2 class channel", {reg_push, pri_push}, exp_pri ? 24'd1 : 24'd2);
            chk(got[22:19] == 4'(SINK), "R3 sink field", 24'(got[22:19]), 24'(SINK));
            chk(got[3:0] == exp_flit[3:0], "R4 R5 stamp field", 24'(got[3:0]), 24'(exp_flit[3:0]));
            chk(got == exp_flit, "R1 flit layout", got, exp_flit);
            have = 0;
        end else begin
            chk(!reg_push && !pri_push, "R6 no push while full or empty",
                {reg_push, pri_push}, 24'd0);
        end
        if (in_valid && er) begin
            have     = 1;
            exp_pri  = in_prio;
            exp_flit = build(in_prio, in_src, in_sel, in_data, stamp_en, tcount);
        end
        tcount = (tcount == TS_MAX) ? 0 : tcount + 1;
    endtask

    task automatic rand_record(int valid_pct);
        in_valid = ($urandom_range(99) < valid_pct);
        in_prio  = $urandom_range(1);
        in_src   = 4'($urandom);
        in_sel   = 3'($urandom);
        in_data  = 8'($urandom);
        stamp_en = ($urandom_range(3) != 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        #1;
        // R9 reset state
        chk(in_ready && !reg_push && !pri_push, "R9 reset idle",
            {in_ready, reg_push, pri_push}, 24'd4);
        @(negedge clk);
        rst_n = 1'b1;
        tcount = 0;
        cycle_check();

        // directed: priority queue full longer than a timer period (R7, R4)
        @(negedge clk);
        pri_full = 1; reg_full = 0;
        in_valid = 1; in_prio = 1; in_src = 4'hA; in_sel = 3'd5; in_data = 8'hC3; stamp_en = 1;
        cycle_check();
        for (int i = 0; i < 2 * (TS_MAX + 1) + 3; i++) begin
            @(negedge clk);
            rand_record(100);
            cycle_check();
        end
        @(negedge clk);
        pri_full = 0; in_valid = 0;
        cycle_check();

        // directed: one record every cycle across two wraps (R5, R8)
        for (int i = 0; i < 2 * (TS_MAX + 1) + 2; i++) begin
            @(negedge clk);
            rand_record(100);
            stamp_en = 1; reg_full = 0; pri_full = 0;
            cycle_check();
        end

        // directed: stamp disabled (R4)
        @(negedge clk);
        rand_record(100);
        stamp_en = 0;
        cycle_check();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            rand_record(70);
            if ($urandom_range(3) == 0) reg_full = ~reg_full;
            if ($urandom_range(3) == 0) pri_full = ~pri_full;
            cycle_check();
        end

        // drain
        @(negedge clk);
        in_valid = 0; reg_full = 0; pri_full = 0;
        cycle_check();
        @(negedge clk);
        cycle_check();
        chk(!have, "R7 nothing left held", 24'(have), 24'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule